// File: doc/BRIEF.md
# Output Protection Supervisor

This block watches a set of fault flags from the analog front end of a programmable source. The flags cover over-current, over-voltage, over-temperature, reverse energy flow (back-drive), a broken sense connection and an open safety interlock. From these flags it decides what the output stage may do. It has four states. Normal drives the output freely. Limit keeps the output on with a current limiter engaged. Trip turns the output off. Recover brings the output back up in a controlled way.

Milder conditions lead to Limit: a qualified over-current in clamp or foldback style, or a qualified over-temperature. Severe conditions lead to Trip. Trip is left by an automatic timer, by a manual reset once all flags are clear, or never if the retry budget is spent. When the interlock opens, the supervisor first requests a ramp-down and opens the output relay only after the ramp. On resume it precharges before it closes the relay. Every entry into Limit or Trip leaves a fault record on a one-cycle strobe.

Top module: `prot_guard`

## Requirements
- R1: After reset the state is Normal (code 0), `out_en` is 1, `retry_o` is 0, and `lim_en`, `lim_fold`, `ramp_req`, `relay_open`, `precharge_en` and `log_valid` are 0.
- R2: `flt_oc` acts only after it has been sampled high on `cfg_oc_deb` consecutive clock edges. `flt_ot` acts only after `cfg_ot_deb` such edges. A shorter pulse leaves the state unchanged.
- R3: A qualified over-current with `cfg_oc_style` 0 (clamp) or 1 (foldback) moves Normal to Limit (code 1). In Limit, `out_en` is 1 and `lim_en` is 1. `lim_fold` is 1 only with style 1. A qualified over-temperature also enters Limit.
- R4: Limit returns to Normal only after every fault flag has been low for `cfg_clr` consecutive edges. A flag that is raised during the count restarts it.
- R5: `flt_ilk`, `flt_ov`, `flt_bd`, `flt_sns`, or a qualified over-current with style 2 (hiccup), moves the block to Trip (code 2) on the next edge, with `out_en` 0.
- R6: In Trip, once all flags are clear for `cfg_off` edges, the block enters Recover (code 3) and `retry_o` goes up by one. Recover drives `out_en` 1 for `cfg_on` edges and then returns to Normal. A fault during Recover re-enters Trip.
- R7: When `retry_o` equals `cfg_max_retry`, or when `cfg_man_only` is 1, Trip is never left automatically. A `man_rst` pulse with all flags clear moves Trip to Recover and clears `retry_o`.
- R8: A Trip with `flt_ilk` high asserts `ramp_req` from the second cycle in Trip for exactly `cfg_ramp` cycles. `relay_open` rises as `ramp_req` falls, and `out_en` stays 0 throughout.
- R9: A Recover that starts with the relay open first holds `precharge_en` 1, `relay_open` 1 and `out_en` 0 for `cfg_pre` cycles. It then closes the relay and drives `out_en` 1.
- R10: Each entry into Limit or Trip pulses `log_valid` for one cycle. The record holds `log_state` (the new state), `log_retry` (the retry count at the event), `log_time` (a cycle timestamp whose differences equal elapsed cycles) and `log_id`. When several causes are active the lowest code wins: interlock 1, over-voltage 2, back-drive 3, sense 4, over-current 5, over-temperature 6.
- R11: `man_rst` is ignored while any fault flag is high; the block stays in Trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_ilk | input | 1 | Safety interlock / emergency stop open |
| flt_ov | input | 1 | Over-voltage comparator |
| flt_bd | input | 1 | Back-drive (reverse energy) comparator |
| flt_sns | input | 1 | Sense-line fault |
| flt_oc | input | 1 | Over-current comparator (debounced) |
| flt_ot | input | 1 | Over-temperature comparator (debounced) |
| man_rst | input | 1 | Manual fault reset request |
| cfg_oc_style | input | 2 | 0 clamp, 1 foldback, 2 hiccup (3 acts as clamp) |
| cfg_oc_deb | input | CW | Over-current debounce edges |
| cfg_ot_deb | input | CW | Over-temperature debounce edges |
| cfg_clr | input | CW | Clear window for leaving Limit |
| cfg_off | input | CW | Off time / recovery timer in Trip |
| cfg_on | input | CW | On window in Recover |
| cfg_ramp | input | CW | Ramp-down length before relay opens |
| cfg_pre | input | CW | Precharge length |
| cfg_max_retry | input | RW | Automatic retry budget |
| cfg_man_only | input | 1 | Disable automatic exit from Trip |
| out_en | output | 1 | Output stage enable |
| lim_en | output | 1 | Current limiter enable |
| lim_fold | output | 1 | Foldback shape select for the limiter |
| ramp_req | output | 1 | Ramp-down request |
| relay_open | output | 1 | Output relay open command |
| precharge_en | output | 1 | Precharge path enable |
| state_o | output | 2 | Current state code |
| retry_o | output | RW | Current retry count |
| log_valid | output | 1 | Fault record strobe |
| log_id | output | 3 | Fault cause code |
| log_state | output | 2 | State entered by the event |
| log_retry | output | RW | Retry count at the event |
| log_time | output | TSW | Cycle timestamp of the event |

## Verification
The state that is hardest to reach from the ports is the latched Trip with a spent retry budget. Reaching it takes a full chain of hiccup cycles. In each cycle the over-current flag has to be raised long enough to qualify, dropped while the output is off, and raised again inside the Recover window. The stimulus runs this chain as a loop of directed phases and checks the logged retry count at every Trip entry. It then confirms that no timer releases the block and that a manual reset is refused while a flag is still up. Debounce boundaries are hit with seeded random pulse lengths around randomly chosen thresholds.

// File: rtl/prot_pkg.sv
package prot_pkg;
   typedef enum logic [1:0] {
      ST_NORM = 2'd0,
      ST_LIM  = 2'd1,
      ST_TRIP = 2'd2,
      ST_RCV  = 2'd3
   } pstate_e;

   localparam logic [1:0] OC_CLAMP = 2'd0;
   localparam logic [1:0] OC_FOLD  = 2'd1;
   localparam logic [1:0] OC_HIC   = 2'd2;

   // source vector bit order: 0 ilk, 1 ov, 2 bd, 3 sns, 4 oc, 5 ot
   localparam int NSRC = 6;
   localparam int FIDW = 3;
endpackage

// File: rtl/prot_deb.sv
module prot_deb #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          raw,
   input  logic [CW-1:0] len,
   output logic          qual
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!raw)    cnt <= '0;
      else if (~&cnt)   cnt <= cnt + 1'b1;
   end

   assign qual = (cnt != '0) && (cnt >= len);
endmodule

// File: rtl/prot_rec.sv
module prot_rec
   import prot_pkg::*;
#(
   parameter int RW  = 4,
   parameter int TSW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   input  logic            take,
   input  logic [1:0]      st_new,
   input  logic [RW-1:0]   retry,
   output logic            log_valid,
   output logic [FIDW-1:0] log_id,
   output logic [1:0]      log_state,
   output logic [RW-1:0]   log_retry,
   output logic [TSW-1:0]  log_time
);
   logic [TSW-1:0]  ts;
   logic [FIDW-1:0] win;

   always_comb begin
      win = '0;
      for (int i = NSRC - 1; i >= 0; i--)
         if (src[i]) win = FIDW'(i + 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ts        <= '0;
         log_valid <= 1'b0;
         log_id    <= '0;
         log_state <= '0;
         log_retry <= '0;
         log_time  <= '0;
      end else begin
         ts        <= ts + 1'b1;
         log_valid <= take;
         if (take) begin
            log_id    <= win;
            log_state <= st_new;
            log_retry <= retry;
            log_time  <= ts;
         end
      end
   end
endmodule

// File: rtl/prot_guard.sv
module prot_guard
   import prot_pkg::*;
#(
   parameter int CW  = 8,
   parameter int RW  = 4,
   parameter int TSW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flt_ilk,
   input  logic            flt_ov,
   input  logic            flt_bd,
   input  logic            flt_sns,
   input  logic            flt_oc,
   input  logic            flt_ot,
   input  logic            man_rst,
   input  logic [1:0]      cfg_oc_style,
   input  logic [CW-1:0]   cfg_oc_deb,
   input  logic [CW-1:0]   cfg_ot_deb,
   input  logic [CW-1:0]   cfg_clr,
   input  logic [CW-1:0]   cfg_off,
   input  logic [CW-1:0]   cfg_on,
   input  logic [CW-1:0]   cfg_ramp,
   input  logic [CW-1:0]   cfg_pre,
   input  logic [RW-1:0]   cfg_max_retry,
   input  logic            cfg_man_only,
   output logic            out_en,
   output logic            lim_en,
   output logic            lim_fold,
   output logic            ramp_req,
   output logic            relay_open,
   output logic            precharge_en,
   output logic [1:0]      state_o,
   output logic [RW-1:0]   retry_o,
   output logic            log_valid,
   output logic [FIDW-1:0] log_id,
   output logic [1:0]      log_state,
   output logic [RW-1:0]   log_retry,
   output logic [TSW-1:0]  log_time
);
   localparam int NDEB = 2;

   generate
      if (CW < 2)  begin : g_bad_cw  $error("CW must be at least 2");  end
      if (RW < 1)  begin : g_bad_rw  $error("RW must be at least 1");  end
      if (TSW < 8) begin : g_bad_tsw $error("TSW must be at least 8"); end
   endgenerate

   // debounced comparators: index 0 over-current, 1 over-temperature
   logic [NDEB-1:0] deb_raw, deb_q;
   logic [CW-1:0]   deb_len [NDEB];
   assign deb_raw    = {flt_ot, flt_oc};
   assign deb_len[0] = cfg_oc_deb;
   assign deb_len[1] = cfg_ot_deb;

   generate
      for (genvar g = 0; g < NDEB; g++) begin : g_deb
         prot_deb #(.CW(CW)) i_deb (
            .clk(clk), .rst_n(rst_n), .raw(deb_raw[g]),
            .len(deb_len[g]), .qual(deb_q[g])
         );
      end
   endgenerate

   pstate_e       st;
   logic [CW-1:0] tmr, rcnt;
   logic          ramp_act, rly, pre;
   logic [RW-1:0] retry;

   logic hic, sev, mild, clean, auto_ok, ev_take;
   pstate_e ev_st;

   function automatic logic hit(input logic [CW-1:0] cnt, input logic [CW-1:0] lim);
      return ({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, lim};
   endfunction

   always_comb begin
      hic     = (cfg_oc_style == OC_HIC);
      sev     = flt_ilk | flt_ov | flt_bd | flt_sns | (deb_q[0] & hic);
      mild    = (deb_q[0] & ~hic) | deb_q[1];
      clean   = ~(flt_ilk | flt_ov | flt_bd | flt_sns | flt_oc | flt_ot);
      auto_ok = ~cfg_man_only && (retry < cfg_max_retry);
      ev_st   = sev ? ST_TRIP : ST_LIM;
      unique case (st)
         ST_NORM: ev_take = sev | mild;
         ST_LIM:  ev_take = sev;
         ST_RCV:  ev_take = sev | (~pre & mild);
         default: ev_take = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_NORM;
         tmr      <= '0;
         rcnt     <= '0;
         ramp_act <= 1'b0;
         rly      <= 1'b0;
         pre      <= 1'b0;
         retry    <= '0;
      end else if (ev_take) begin
         st  <= ev_st;
         tmr <= '0;
         pre <= 1'b0;
      end else begin
         unique case (st)
            ST_NORM: tmr <= '0;
            ST_LIM: begin
               if (!clean)                  tmr <= '0;
               else if (hit(tmr, cfg_clr)) begin
                  st <= ST_NORM; tmr <= '0; retry <= '0;
               end else                     tmr <= tmr + 1'b1;
            end
            ST_TRIP: begin
               if (ramp_act) begin
                  if (hit(rcnt, cfg_ramp)) begin
                     ramp_act <= 1'b0; rly <= 1'b1; rcnt <= '0;
                  end else rcnt <= rcnt + 1'b1;
               end else if (flt_ilk && !rly) begin
                  ramp_act <= 1'b1; rcnt <= '0;
               end
               if (ramp_act || !clean) tmr <= '0;
               else if (man_rst) begin
                  st <= ST_RCV; tmr <= '0; retry <= '0; pre <= rly;
               end else if (!auto_ok)       tmr <= '0;
               else if (hit(tmr, cfg_off)) begin
                  st <= ST_RCV; tmr <= '0; retry <= retry + 1'b1; pre <= rly;
               end else                     tmr <= tmr + 1'b1;
            end
            ST_RCV: begin
               if (pre) begin
                  if (hit(tmr, cfg_pre)) begin
                     pre <= 1'b0; rly <= 1'b0; tmr <= '0;
                  end else tmr <= tmr + 1'b1;
               end else if (hit(tmr, cfg_on)) begin
                  st <= ST_NORM; tmr <= '0; retry <= '0;
               end else tmr <= tmr + 1'b1;
            end
            default: st <= ST_NORM;
         endcase
      end
   end

   assign out_en       = (st == ST_NORM) | (st == ST_LIM) | ((st == ST_RCV) & ~pre);
   assign lim_en       = (st == ST_LIM);
   assign lim_fold     = (st == ST_LIM) & (cfg_oc_style == OC_FOLD);
   assign ramp_req     = ramp_act;
   assign relay_open   = rly;
   assign precharge_en = (st == ST_RCV) & pre;
   assign state_o      = st;
   assign retry_o      = retry;

   prot_rec #(.RW(RW), .TSW(TSW)) i_rec (
      .clk(clk), .rst_n(rst_n),
      .src({deb_q[1], deb_q[0], flt_sns, flt_bd, flt_ov, flt_ilk}),
      .take(ev_take), .st_new(ev_st), .retry(retry),
      .log_valid(log_valid), .log_id(log_id), .log_state(log_state),
      .log_retry(log_retry), .log_time(log_time)
   );
endmodule

// File: rtl/prot_guard_chk.sv
module prot_guard_chk #(
   parameter int RW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          flt_ilk,
   input logic          flt_oc,
   input logic          flt_ot,
   input logic          out_en,
   input logic          ramp_req,
   input logic          relay_open,
   input logic          precharge_en,
   input logic [1:0]    state_o,
   input logic [RW-1:0] retry_o,
   input logic          log_valid,
   input logic [1:0]    log_state
);
   // R8: relay only opens at the end of a ramp
   a_r8_relay_after_ramp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(relay_open) |-> $past(ramp_req));
   // R8: a ramp only starts with the interlock open
   a_r8_ramp_needs_ilk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ramp_req) |-> $past(flt_ilk));
   // R8: output stays off while ramping
   a_r8_off_in_ramp: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_req |-> !out_en);
   // R9: precharge only with the relay open and output off
   a_r9_precharge_safe: assert property (@(posedge clk) disable iff (!rst_n)
      precharge_en |-> (relay_open && !out_en));
   // R6: retry count climbs one step at a time
   a_r6_retry_step: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_o != $past(retry_o) && retry_o != '0) |-> (retry_o == $past(retry_o) + 1'b1));
   // R10: a record strobe marks a state change into the logged state
   a_r10_log_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid |-> (state_o != $past(state_o) && state_o == log_state));
   // R2: Limit from Normal needs a raised comparator behind it
   a_r2_limit_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1 && $past(state_o) == 2'd0) |-> ($past(flt_oc, 2) || $past(flt_ot, 2)));
endmodule

bind prot_guard prot_guard_chk #(.RW(RW)) i_chk (
   .clk(clk), .rst_n(rst_n), .flt_ilk(flt_ilk), .flt_oc(flt_oc), .flt_ot(flt_ot),
   .out_en(out_en), .ramp_req(ramp_req), .relay_open(relay_open),
   .precharge_en(precharge_en), .state_o(state_o), .retry_o(retry_o),
   .log_valid(log_valid), .log_state(log_state)
);

// File: tb/test_prot_guard.sv
module test_prot_guard;
   localparam int CW = 8, RW = 4, TSW = 16;
   localparam int S_NORM = 0, S_LIM = 1, S_TRIP = 2, S_RCV = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flt_ilk = 0, flt_ov = 0, flt_bd = 0, flt_sns = 0, flt_oc = 0, flt_ot = 0, man_rst = 0;
   logic [1:0] cfg_oc_style = 2'd0;
   logic [CW-1:0] cfg_oc_deb = 8'd3, cfg_ot_deb = 8'd4, cfg_clr = 8'd5, cfg_off = 8'd6;
   logic [CW-1:0] cfg_on = 8'd4, cfg_ramp = 8'd3, cfg_pre = 8'd2;
   logic [RW-1:0] cfg_max_retry = 4'd3;
   logic cfg_man_only = 1'b0;
   logic out_en, lim_en, lim_fold, ramp_req, relay_open, precharge_en, log_valid;
   logic [1:0] state_o, log_state;
   logic [RW-1:0] retry_o, log_retry;
   logic [2:0] log_id;
   logic [TSW-1:0] log_time;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   prot_guard #(.CW(CW), .RW(RW), .TSW(TSW)) i_prot_guard (.*);

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_st(input int s, input int lim, output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (state_o != s && n < lim);
   endtask

   function automatic int expect_lim(input int pulse, input int deb);
      return (pulse >= deb) ? 1 : 0;
   endfunction

   initial begin
      int n, seen, deb, len, t1, c1;
      int unsigned seed;
      seed = $urandom(32'd613);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 state", state_o, S_NORM);
      chk("R1 out_en", out_en, 1);
      chk("R1 flags", {lim_en, lim_fold, ramp_req, relay_open, precharge_en, log_valid}, 0);
      chk("R1 retry", retry_o, 0);

      // R2 random over-current pulses around the debounce length
      for (int i = 0; i < 12; i++) begin
         deb = 1 + ($urandom % 6);
         len = 1 + ($urandom % 8);
         cfg_oc_deb = CW'(deb);
         flt_oc = 1'b1;
         seen = 0;
         for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (state_o == S_LIM) seen = 1;
         end
         flt_oc = 1'b0;
         for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            if (state_o == S_LIM) seen = 1;
         end
         chk($sformatf("R2 oc pulse %0d deb %0d", len, deb), seen, expect_lim(len, deb));
         wait_st(S_NORM, 40, n);
         repeat (2) @(negedge clk);
      end

      // R2 over-temperature debounce: 3 edges short of 4, then 4 qualifies
      flt_ot = 1'b1; repeat (3) @(negedge clk); flt_ot = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 ot short pulse ignored", state_o, S_NORM);
      flt_ot = 1'b1; wait_st(S_LIM, 10, n); flt_ot = 1'b0;
      chk("R2 ot qualifies after 4", n, 5);
      chk("R10 ot id", log_id, 6);
      wait_st(S_NORM, 40, n);

      // R3 foldback Limit and R10 record
      cfg_oc_style = 2'd1; cfg_oc_deb = 8'd2;
      flt_oc = 1'b1;
      wait_st(S_LIM, 10, n);
      chk("R3 fold lim_en", lim_en, 1);
      chk("R3 fold lim_fold", lim_fold, 1);
      chk("R3 out_en in Limit", out_en, 1);
      chk("R10 log strobe", log_valid, 1);
      chk("R10 oc id", log_id, 5);
      chk("R10 log state", log_state, S_LIM);
      t1 = log_time; c1 = cyc;
      @(negedge clk);
      chk("R10 strobe one cycle", log_valid, 0);

      // R4 hysteresis with a restart
      flt_oc = 1'b0;
      repeat (3) @(negedge clk);
      chk("R4 still Limit mid window", state_o, S_LIM);
      flt_ot = 1'b1; @(negedge clk); flt_ot = 1'b0;
      wait_st(S_NORM, 20, n);
      chk("R4 clear window restarted", n, 5);

      // R3 clamp: no foldback
      cfg_oc_style = 2'd0;
      flt_oc = 1'b1; wait_st(S_LIM, 10, n);
      chk("R3 clamp lim_fold", lim_fold, 0);
      chk("R3 clamp lim_en", lim_en, 1);
      flt_oc = 1'b0; wait_st(S_NORM, 20, n);

      // R5 R6 R7 hiccup chain to a latched Trip
      cfg_oc_style = 2'd2; cfg_on = 8'd8;
      for (int k = 0; k <= 3; k++) begin
         flt_oc = 1'b1;
         wait_st(S_TRIP, 20, n);
         chk("R5 hiccup trip out_en", out_en, 0);
         chk("R10 trip retry", log_retry, k);
         chk("R10 trip id", log_id, 5);
         flt_oc = 1'b0;
         if (k < 3) begin
            wait_st(S_RCV, 30, n);
            chk("R6 off time", n, 6);
            chk("R6 retry count", retry_o, k + 1);
            chk("R6 recover on", out_en, 1);
         end
      end
      repeat (20) @(negedge clk);
      chk("R7 latched after max retries", state_o, S_TRIP);
      chk("R7 retry held", retry_o, 3);
      flt_ov = 1'b1; man_rst = 1'b1; @(negedge clk); man_rst = 1'b0;
      chk("R11 reset ignored with flag", state_o, S_TRIP);
      flt_ov = 1'b0; @(negedge clk);
      man_rst = 1'b1; @(negedge clk); man_rst = 1'b0;
      chk("R7 manual reset to Recover", state_o, S_RCV);
      chk("R7 retry cleared", retry_o, 0);
      wait_st(S_NORM, 20, n);
      chk("R6 on window", n, 8);

      // R8 R9 interlock with over-voltage, priority and timestamp
      cfg_oc_style = 2'd0;
      flt_ilk = 1'b1; flt_ov = 1'b1;
      @(negedge clk);
      chk("R5 ilk trips", state_o, S_TRIP);
      chk("R10 ilk beats ov", log_id, 1);
      chk("R10 timestamp", int'(log_time) - t1, cyc - c1);
      n = 0;
      while (!ramp_req && n < 5) begin @(negedge clk); n++; end
      chk("R8 ramp starts second cycle", n, 1);
      n = 0;
      while (ramp_req && n < 20) begin
         if (out_en) chk("R8 out_en during ramp", out_en, 0);
         if (relay_open) chk("R8 relay during ramp", relay_open, 0);
         @(negedge clk); n++;
      end
      chk("R8 ramp length", n, 3);
      chk("R8 relay opens", relay_open, 1);
      flt_ilk = 1'b0; flt_ov = 1'b0;
      wait_st(S_RCV, 30, n);
      chk("R6 safety delay", n, 6);
      chk("R9 precharge on", precharge_en, 1);
      chk("R9 relay still open", relay_open, 1);
      chk("R9 output off", out_en, 0);
      n = 0;
      while (precharge_en && n < 10) begin @(negedge clk); n++; end
      chk("R9 precharge length", n, 2);
      chk("R9 relay closed", relay_open, 0);
      chk("R9 output back", out_en, 1);
      wait_st(S_NORM, 20, n);

      // R7 manual-only policy, R10 back-drive over sense
      cfg_man_only = 1'b1;
      flt_bd = 1'b1; flt_sns = 1'b1;
      @(negedge clk);
      chk("R10 bd beats sense", log_id, 3);
      flt_bd = 1'b0; flt_sns = 1'b0;
      repeat (20) @(negedge clk);
      chk("R7 manual only holds Trip", state_o, S_TRIP);
      man_rst = 1'b1; @(negedge clk); man_rst = 1'b0;
      chk("R7 manual release", state_o, S_RCV);
      cfg_man_only = 1'b0;
      wait_st(S_NORM, 20, n);
      chk("R6 back to Normal", state_o, S_NORM);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule